// File: doc/BRIEF.md
# Scanline-Clocked Interrupt Counter

This block raises a level interrupt to a processor after a programmed number of video scanlines. An 8-bit down-counter takes one step per scanline. A one-cycle pulse from outside the block marks each scanline. When the counter is zero, it reloads from a latch instead of stepping down. When a step or a reload leaves the counter at zero and interrupts are enabled, the interrupt line rises. It stays high until software disables interrupts.

Software controls the block through byte writes in the upper quarter of the processor address space. The top three address bits pick the region: `110` selects the counter registers and `111` selects the interrupt-enable control. Address bit 0 picks one of two actions inside each region. The current count is brought out so that the state can be observed.

Top module: `scanline_irq_counter`

## Requirements
- R1: After synchronous reset, `count` is 0, `irq` is 0, the reload latch is 0 and interrupts are disabled.
- R2: A write with address bits [15:13] = `110` and bit 0 = 0 stores `wr_data` as the reload latch. `count` does not change unless a pulse arrives.
- R3: A write with address bits [15:13] = `110` and bit 0 = 1 only marks a reload as pending. `count` keeps its value until the next `line_pulse`.
- R4: On a `line_pulse`, the counter loads the latch value if `count` is 0 or a reload is pending. The pulse also clears the pending mark.
- R5: On a `line_pulse` with `count` nonzero and no reload pending, `count` decreases by exactly one.
- R6: If the count after a pulse's update is 0 and interrupts are enabled, `irq` is 1 in the cycle after that pulse.
- R7: A write with address bits [15:13] = `111` and bit 0 = 1 enables interrupts. The same region with bit 0 = 0 disables interrupts and drops `irq` in the next cycle.
- R8: Once high, `irq` stays high through later pulses until a disable write.
- R9: A write and a `line_pulse` in the same cycle both take effect, and the write is applied first. A new latch value, a pending mark or an enable change is therefore already seen by that pulse.
- R10: Writes with address bit 15 = 0 or with bits [15:13] = `101` change no state. The pulse in the same cycle behaves as if there were no write.
- R11: While interrupts are disabled, a count that reaches 0 does not raise `irq`. Enabling interrupts later does not raise `irq` until a pulse leaves the count at zero.
- R12: A latch of 0 with interrupts enabled raises `irq` on every pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Processor write strobe, one cycle per write |
| wr_addr | input | 16 | Processor write address |
| wr_data | input | 8 | Processor write data |
| line_pulse | input | 1 | One-cycle pulse per scanline |
| irq | output | 1 | Level interrupt request |
| count | output | 8 | Current counter value |

## Verification
The bench builds the block with its default parameters: an 8-bit counter and latch, and a 16-bit address. With these widths, a small latch value such as 3 or 5 brings the zero crossing within a handful of pulses. The reload-at-zero path, the sticky interrupt and the zero-latch case that fires on every line therefore all fit in one short vector sequence. The same-cycle cases pair each kind of write with a pulse, so the ordering rule is visible in `count` and `irq` one cycle later.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;

    localparam int unsigned REGION_BITS = 3;
    localparam logic [REGION_BITS-1:0] REGION_COUNTER = 3'b110;
    localparam logic [REGION_BITS-1:0] REGION_ENABLE  = 3'b111;

    typedef struct packed {
        logic load_latch;
        logic mark_reload;
        logic irq_on;
        logic irq_off;
    } sirq_cmd_t;

    localparam sirq_cmd_t CMD_NONE = '{default: 1'b0};

endpackage

// File: rtl/scanline_irq_decode.sv
module scanline_irq_decode
    import scanline_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output sirq_cmd_t         cmd
);
    localparam int unsigned TOP_LSB = ADDR_W - REGION_BITS;

    logic [REGION_BITS-1:0] region;
    logic                   addr_unused;

    assign region      = wr_addr[ADDR_W-1:TOP_LSB];
    assign addr_unused = ^wr_addr[TOP_LSB-1:1];

    always_comb begin
        cmd = CMD_NONE;
        if (wr_en) begin
            unique case (region)
                REGION_COUNTER: begin
                    cmd.load_latch  = ~wr_addr[0];
                    cmd.mark_reload =  wr_addr[0];
                end
                REGION_ENABLE: begin
                    cmd.irq_off = ~wr_addr[0];
                    cmd.irq_on  =  wr_addr[0];
                end
                default: cmd = CMD_NONE;
            endcase
        end
    end
endmodule

// File: rtl/scanline_irq_count.sv
module scanline_irq_count
    import scanline_irq_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  sirq_cmd_t        cmd,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             line_pulse,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_next,
    output logic             reload_pend
);
    logic [CNT_W-1:0] latch_q, latch_n;
    logic             pend_w, pend_n;

    always_comb begin
        // writes take effect before the scanline step
        latch_n    = cmd.load_latch ? wr_data : latch_q;
        pend_w     = reload_pend | cmd.mark_reload;
        count_next = count;
        pend_n     = pend_w;
        if (line_pulse) begin
            if (count == '0 || pend_w) begin
                count_next = latch_n;
                pend_n     = 1'b0;
            end else begin
                count_next = count - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count       <= '0;
            latch_q     <= '0;
            reload_pend <= 1'b0;
        end else begin
            count       <= count_next;
            latch_q     <= latch_n;
            reload_pend <= pend_n;
        end
    end
endmodule

// File: rtl/scanline_irq_flag.sv
module scanline_irq_flag
    import scanline_irq_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  sirq_cmd_t        cmd,
    input  logic             line_pulse,
    input  logic [CNT_W-1:0] count_next,
    output logic             irq
);
    logic enable_q, enable_n, irq_n;

    always_comb begin
        enable_n = enable_q;
        if (cmd.irq_on)  enable_n = 1'b1;
        if (cmd.irq_off) enable_n = 1'b0;
        irq_n = cmd.irq_off ? 1'b0 : irq;
        if (line_pulse && enable_n && count_next == '0)
            irq_n = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= 1'b0;
            irq      <= 1'b0;
        end else begin
            enable_q <= enable_n;
            irq      <= irq_n;
        end
    end
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
    import scanline_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              line_pulse,
    output logic              irq,
    output logic [CNT_W-1:0]  count
);
    sirq_cmd_t        cmd;
    logic [CNT_W-1:0] count_next;
    logic             reload_pend;

    scanline_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .cmd     (cmd)
    );

    scanline_irq_count #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .wr_data     (wr_data),
        .line_pulse  (line_pulse),
        .count       (count),
        .count_next  (count_next),
        .reload_pend (reload_pend)
    );

    scanline_irq_flag #(.CNT_W(CNT_W)) u_flag (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .line_pulse (line_pulse),
        .count_next (count_next),
        .irq        (irq)
    );
endmodule

// File: rtl/scanline_irq_chk.sv
module scanline_irq_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CNT_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              line_pulse,
    input logic              irq,
    input logic [CNT_W-1:0]  count,
    input logic              pend
);
    logic off_wr, reload_wr, addr_unused;
    assign off_wr      = wr_en && wr_addr[ADDR_W-1 -: 3] == 3'b111 && !wr_addr[0];
    assign reload_wr   = wr_en && wr_addr[ADDR_W-1 -: 3] == 3'b110 &&  wr_addr[0];
    assign addr_unused = ^wr_addr[ADDR_W-4:1];

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (count == '0 && !irq));

    // R3
    hold_without_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !line_pulse |=> $stable(count));

    // R5
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        (line_pulse && count != '0 && !pend && !reload_wr) |=> count == $past(count) - CNT_W'(1));

    // R6
    irq_needs_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(line_pulse) && count == '0));

    // R7
    disable_drops_chk: assert property (@(posedge clk) disable iff (rst)
        off_wr |=> !irq);

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !off_wr) |=> irq);
endmodule

bind scanline_irq_counter scanline_irq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .line_pulse (line_pulse),
    .irq        (irq),
    .count      (count),
    .pend       (reload_pend)
);

// File: tb/sim_scanline_irq_counter.sv
module sim_scanline_irq_counter;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 22;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        line_pulse = 1'b0;
    logic        irq;
    logic [7:0]  count;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scanline_irq_counter u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .line_pulse(line_pulse), .irq(irq), .count(count)
    );

    // {we, addr, data, pulse, expected count, expected irq}
    localparam logic [34:0] VEC [NV] = '{
        {1'b1, 16'hC000, 8'd3,   1'b0, 8'd0, 1'b0}, // R2 latch only
        {1'b0, 16'h0000, 8'd0,   1'b1, 8'd3, 1'b0}, // R4 zero reloads, R11 disabled
        {1'b0, 16'h0000, 8'd0,   1'b1, 8'd2, 1'b0}, // R5
        {1'b1, 16'hE001, 8'd0,   1'b0, 8'd2, 1'b0}, // R7 enable, R11 no irq yet
        {1'b0, 16'h0000, 8'd0,   1'b1, 8'd1, 1'b0}, // R5
        {1'b0, 16'h0000, 8'd0,   1'b1, 8'd0, 1'b1}, // R6
        {1'b0, 16'h0000, 8'd0,   1'b1, 8'd3, 1'b1}, // R8 sticky, R4 reload
        {1'b1, 16'hE000, 8'd0,   1'b0, 8'd3, 1'b0}, // R7 disable clears
        {1'b1, 16'hC001, 8'd0,   1'b0, 8'd3, 1'b0}, // R3 no direct change
        {1'b0, 16'h0000, 8'd0,   1'b1, 8'd3, 1'b0}, // R3 R4 pending reload
        {1'b0, 16'h0000, 8'd0,   1'b1, 8'd2, 1'b0}, // R5
        {1'b1, 16'hC000, 8'd5,   1'b1, 8'd1, 1'b0}, // R9 latch + step
        {1'b1, 16'hC001, 8'd0,   1'b1, 8'd5, 1'b0}, // R9 mark + pulse reloads new latch
        {1'b1, 16'hA001, 8'hFF,  1'b1, 8'd4, 1'b0}, // R10 ignored region
        {1'b1, 16'h8000, 8'd0,   1'b0, 8'd4, 1'b0}, // R10 ignored region
        {1'b1, 16'h4000, 8'd0,   1'b1, 8'd3, 1'b0}, // R10 low address
        {1'b1, 16'hFFFF, 8'd0,   1'b1, 8'd2, 1'b0}, // R9 R7 enable with pulse
        {1'b0, 16'h0000, 8'd0,   1'b1, 8'd1, 1'b0}, // R5
        {1'b0, 16'h0000, 8'd0,   1'b1, 8'd0, 1'b1}, // R6
        {1'b1, 16'hE000, 8'd0,   1'b1, 8'd5, 1'b0}, // R9 disable with pulse
        {1'b1, 16'hDFFE, 8'd0,   1'b0, 8'd5, 1'b0}, // R2 latch 0 held, R12 setup
        {1'b1, 16'hE001, 8'd0,   1'b0, 8'd5, 1'b0}  // R7
    };

    task automatic check(input string req, input logic [7:0] exp_c, input logic exp_i);
        n_checks++;
        if (count !== exp_c || irq !== exp_i) begin
            n_fail++;
            $display("FAIL %s: count=%0d irq=%0b expected count=%0d irq=%0b",
                     req, count, irq, exp_c, exp_i);
        end
    endtask

    task automatic tick(input logic we, input logic [15:0] a, input logic [7:0] d, input logic p);
        wr_en = we; wr_addr = a; wr_data = d; line_pulse = p;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; line_pulse = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        check("R1 reset", 8'd0, 1'b0);
        for (int i = 0; i < NV; i++) begin
            tick(VEC[i][34], VEC[i][33:18], VEC[i][17:10], VEC[i][9]);
            check($sformatf("vector %0d", i), VEC[i][8:1], VEC[i][0]);
        end
        // R12: latch 0, enabled -> irq on each pulse
        tick(1'b0, 16'h0, 8'd0, 1'b1); check("R12 pending? count 5->4", 8'd4, 1'b0);
        tick(1'b1, 16'hC001, 8'd0, 1'b1); check("R12 reload zero latch", 8'd0, 1'b1);
        tick(1'b1, 16'hE000, 8'd0, 1'b0); check("R7 clear", 8'd0, 1'b0);
        tick(1'b1, 16'hE001, 8'd0, 1'b1); check("R12 fires again", 8'd0, 1'b1);
        // R1: reset mid-run clears latch, enable and irq
        tick(1'b1, 16'hC000, 8'd9, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid-run reset", 8'd0, 1'b0);
        tick(1'b0, 16'h0, 8'd0, 1'b1); check("R1 latch cleared, enable off", 8'd0, 1'b0);
        tick(1'b1, 16'hE001, 8'd0, 1'b0); check("R11 enable alone no irq", 8'd0, 1'b0);
        tick(1'b0, 16'h0, 8'd0, 1'b1); check("R12 after reset", 8'd0, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule